// File: doc/BRIEF.md
# Weighted Rail Readiness Voter

This block turns the already-qualified "good" flags of several supply rails into one system-ready decision. Each rail has a 2-bit importance weight. The block adds the weights of the rails that are good right now and compares that total with a programmed threshold. A rail that is important to the system gets a larger weight. With several rails of equal weight, the threshold sets how many of them must agree.

The first decision is not taken at the moment a rail turns good. The first rising good flag opens an alignment window of programmable length. The vote is sampled only when that window closes, so an early rail cannot decide alone. After the window the vote follows the weighted total on every clock. When the vote drops, the block goes back to waiting for a new rising flag.

Each rail also has a penalty counter. A chatter event on the rail's glitch input raises the counter, and a shared rate timer lowers it at a steady pace. A penalty above the programmed limit raises a degraded flag. It does not take the vote away.

Top module: `weighted_rail_voter`

## Requirements
- R1: Rail i's weight is the unsigned 2-bit field rail_weight[2i+1:2i] (0 to 3). Only rails whose rail_valid bit is 1 add their weight to the live total, so a valid rail with weight 0 never changes the vote.
- R2: Once the alignment window has closed, vote_ok is registered each clock as (live total >= vote_thresh). It rises or falls on the first clock edge after the total crosses the threshold.
- R3: When vote_thresh exceeds the sum of all rail weights, cfg_bad is 1 (combinationally) and vote_ok is 0 from the next clock edge on. Once the threshold is back in range, the vote is free again.
- R4: From the idle state, the first clock edge that sees a rail_valid bit go 0 to 1 opens the window. vote_ok stays 0 until edge number align_len after that edge, where it first takes the sampled vote. An align_len of 0 behaves as 1.
- R5: A falling vote_ok returns the block to idle. No vote is given again until a new rising rail_valid bit opens a fresh, full alignment window.
- R6: Every clock with rail_glitch[i]=1 raises rail i's penalty (field rail_penalty[4i+3:4i]) by one. The count saturates at 15.
- R7: A shared rate timer fires on edge number rate_len after reset and then every rate_len edges. Each firing lowers every nonzero penalty by one. A glitch and a firing on the same edge cancel each other.
- R8: degraded is 1 exactly while some rail's penalty is strictly greater than pen_max. Degraded never clears vote_ok.
- R9: With three rails of weight 1 and a threshold of 2, toggling one rail's valid flag on every clock keeps vote_ok at 1.
- R10: During and right after reset, vote_ok, degraded and all penalties are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_valid | input | N_RAILS | Per-rail qualified good flag |
| rail_glitch | input | N_RAILS | Per-rail chatter event, one count per cycle high |
| rail_weight | input | 2*N_RAILS | Packed 2-bit weights, rail 0 in the low bits |
| vote_thresh | input | SUM_W | Required weighted total |
| align_len | input | WIN_W | Alignment window length in clocks |
| rate_len | input | RATE_W | Penalty decay period in clocks |
| pen_max | input | PEN_W | Penalty limit for degraded |
| vote_ok | output | 1 | Weighted readiness decision |
| degraded | output | 1 | Some rail's penalty is over the limit |
| cfg_bad | output | 1 | Threshold above total weight, vote blocked |
| rail_penalty | output | PEN_W*N_RAILS | Packed penalty counters, rail 0 in the low bits |

## Verification
The in-line properties check these rules on every clock:
- no vote while the block is idle or inside the window;
- the vote drops after an out-of-range threshold;
- a rising vote had a sufficient total behind it, and a falling vote leads to idle;
- penalties hold when glitch and decay balance, step by exactly one, and stay at saturation;
- a degraded rail does not clear a standing vote.

Only the directed scenarios can show the rest:
- the exact edge on which the window closes;
- that a zero weight is ignored;
- the decay timing against the rate period;
- the full window after a re-arm;
- that a fluttering rail is tolerated in a two-of-three setup.

// File: rtl/wvote_pkg.sv
// Shared definitions for the weighted rail voter.
// Assumes weights are always two bits wide.
package wvote_pkg;
    localparam int unsigned WEIGHT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_EVAL  = 2'd2
    } vote_state_e;
endpackage

// File: rtl/wvote_wsum.sv
// Weighted total of the valid rails, plus a range check on the threshold.
// Purely combinational. SUM_W must hold N_RAILS*3.
module wvote_wsum
    import wvote_pkg::*;
#(
    parameter int unsigned N_RAILS = 4,
    parameter int unsigned SUM_W   = 4
) (
    input  logic [N_RAILS-1:0]          valid,
    input  logic [N_RAILS*WEIGHT_W-1:0] weight,
    input  logic [SUM_W-1:0]            thresh,
    output logic [SUM_W-1:0]            live_sum,
    output logic                        meets,
    output logic                        cfg_bad
);
    logic [SUM_W-1:0] total_sum;

    // Accumulate the live total and the total of all weights.
    always_comb begin
        live_sum  = '0;
        total_sum = '0;
        for (int i = 0; i < int'(N_RAILS); i++) begin
            total_sum = total_sum + SUM_W'(weight[i*WEIGHT_W +: WEIGHT_W]);
            if (valid[i]) begin
                live_sum = live_sum + SUM_W'(weight[i*WEIGHT_W +: WEIGHT_W]);
            end
        end
    end

    // Reject an unreachable threshold; otherwise compare the live total.
    always_comb begin
        cfg_bad = (thresh > total_sum);
        meets   = !cfg_bad && (live_sum >= thresh);
    end
endmodule

// File: rtl/wvote_rate.sv
// Free-running decay timer: one-cycle tick every rate_len clocks.
// A rate_len of 0 or 1 ticks every clock.
module wvote_rate #(
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_len,
    output logic              tick
);
    logic [RATE_W-1:0] cnt;

    // Tick once the counter reaches the end of the period.
    always_comb begin
        tick = (rate_len <= RATE_W'(1)) || (cnt >= rate_len - RATE_W'(1));
    end

    // Advance the period counter and restart it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + RATE_W'(1);
        end
    end

    p_tick_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
endmodule

// File: rtl/wvote_pen.sv
// Per-rail chatter penalty: up on glitch, down on decay tick, saturating both ways.
// Assumes glitch is already a clean one-cycle-per-event signal.
module wvote_pen #(
    parameter int unsigned PEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glitch,
    input  logic             tick,
    input  logic [PEN_W-1:0] pen_max,
    output logic [PEN_W-1:0] pen,
    output logic             over
);
    localparam logic [PEN_W-1:0] PEN_TOP = {PEN_W{1'b1}};

    // Move the penalty by one step according to glitch and decay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen <= '0;
        end else begin
            case ({glitch, tick})
                2'b10:   if (pen != PEN_TOP) pen <= pen + PEN_W'(1);
                2'b01:   if (pen != '0) pen <= pen - PEN_W'(1);
                default: pen <= pen;
            endcase
        end
    end

    // Flag a penalty strictly over the limit.
    always_comb begin
        over = (pen > pen_max);
    end

    p_pen_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (glitch == tick) |=> $stable(pen));
    p_pen_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glitch && !tick && pen != PEN_TOP) |=> (pen == $past(pen) + PEN_W'(1)));
    p_pen_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glitch && pen == PEN_TOP) |=> (pen == PEN_TOP));
endmodule

// File: rtl/wvote_align.sv
// Alignment window and vote register.
// Idle waits for a rising valid flag, Align counts align_len clocks,
// Eval tracks the weighted comparison every clock and returns to Idle when the vote falls.
module wvote_align
    import wvote_pkg::*;
#(
    parameter int unsigned N_RAILS = 4,
    parameter int unsigned WIN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] valid,
    input  logic               meets,
    input  logic               cfg_bad,
    input  logic [WIN_W-1:0]   align_len,
    output logic               vote_ok
);
    vote_state_e        state;
    logic [N_RAILS-1:0] valid_q;
    logic [WIN_W-1:0]   cnt;
    logic               rise;
    logic               win_last;

    // Detect a new rail rise and the last clock of the window.
    always_comb begin
        rise     = |(valid & ~valid_q);
        win_last = (align_len <= WIN_W'(1)) || (cnt >= align_len - WIN_W'(1));
    end

    // Keep last cycle's flags for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid;
    end

    // Sequence Idle, Align and Eval, and register the vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            vote_ok <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    vote_ok <= 1'b0;
                    if (rise) begin
                        state <= ST_ALIGN;
                        cnt   <= '0;
                    end
                end
                ST_ALIGN: begin
                    if (win_last) begin
                        state   <= ST_EVAL;
                        vote_ok <= meets;
                    end else begin
                        cnt <= cnt + WIN_W'(1);
                    end
                end
                ST_EVAL: begin
                    if (vote_ok && !meets) begin
                        state   <= ST_IDLE;
                        vote_ok <= 1'b0;
                    end else begin
                        vote_ok <= meets;
                    end
                end
                default: begin
                    state   <= ST_IDLE;
                    vote_ok <= 1'b0;
                end
            endcase
        end
    end

    p_no_vote_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN) |-> !vote_ok);
    p_idle_no_vote_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !vote_ok);
    p_drop_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_ok && !meets) |=> (!vote_ok && state == ST_IDLE));
    p_cfg_blocks_vote_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> !vote_ok);
endmodule

// File: rtl/weighted_rail_voter.sv
// Top of the weighted rail readiness voter.
// Rail flags are assumed to be synchronous and already deglitched.
// The weighted total, the window sequencer, the decay timer and one penalty counter per rail are instantiated here.
module weighted_rail_voter
    import wvote_pkg::*;
#(
    parameter int unsigned N_RAILS = 4,
    parameter int unsigned WIN_W   = 16,
    parameter int unsigned RATE_W  = 16,
    parameter int unsigned PEN_W   = 4,
    localparam int unsigned SUM_W  = $clog2(N_RAILS * 3 + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_RAILS-1:0]          rail_valid,
    input  logic [N_RAILS-1:0]          rail_glitch,
    input  logic [N_RAILS*WEIGHT_W-1:0] rail_weight,
    input  logic [SUM_W-1:0]            vote_thresh,
    input  logic [WIN_W-1:0]            align_len,
    input  logic [RATE_W-1:0]           rate_len,
    input  logic [PEN_W-1:0]            pen_max,
    output logic                        vote_ok,
    output logic                        degraded,
    output logic                        cfg_bad,
    output logic [N_RAILS*PEN_W-1:0]    rail_penalty
);
    logic [SUM_W-1:0]   live_sum;
    logic               meets;
    logic               decay_tick;
    logic [N_RAILS-1:0] over;

    wvote_wsum #(.N_RAILS(N_RAILS), .SUM_W(SUM_W)) i_wsum (
        .valid    (rail_valid),
        .weight   (rail_weight),
        .thresh   (vote_thresh),
        .live_sum (live_sum),
        .meets    (meets),
        .cfg_bad  (cfg_bad)
    );

    wvote_align #(.N_RAILS(N_RAILS), .WIN_W(WIN_W)) i_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (rail_valid),
        .meets     (meets),
        .cfg_bad   (cfg_bad),
        .align_len (align_len),
        .vote_ok   (vote_ok)
    );

    wvote_rate #(.RATE_W(RATE_W)) i_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_len (rate_len),
        .tick     (decay_tick)
    );

    for (genvar g = 0; g < int'(N_RAILS); g++) begin : g_rail
        wvote_pen #(.PEN_W(PEN_W)) i_pen (
            .clk     (clk),
            .rst_n   (rst_n),
            .glitch  (rail_glitch[g]),
            .tick    (decay_tick),
            .pen_max (pen_max),
            .pen     (rail_penalty[g*PEN_W +: PEN_W]),
            .over    (over[g])
        );
    end

    // Any rail over its penalty limit marks the system degraded.
    always_comb begin
        degraded = |over;
    end

    p_rise_has_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vote_ok) |-> $past(live_sum >= vote_thresh));
    p_degraded_keeps_vote_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_ok && degraded && meets) |=> vote_ok);
endmodule

// File: tb/test_weighted_rail_voter.sv
module test_weighted_rail_voter;
    localparam int N = 4;
    localparam int SW = $clog2(N * 3 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  valid = '0;
    logic [N-1:0]  glitch = '0;
    logic [2*N-1:0] weight = '0;
    logic [SW-1:0] thresh = '0;
    logic [15:0]   align_len = 16'd4;
    logic [15:0]   rate_len = 16'd1000;
    logic [3:0]    pen_max = 4'd2;
    logic          vote_ok, degraded, cfg_bad;
    logic [4*N-1:0] penalty;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    weighted_rail_voter i_weighted_rail_voter (
        .clk(clk), .rst_n(rst_n), .rail_valid(valid), .rail_glitch(glitch),
        .rail_weight(weight), .vote_thresh(thresh), .align_len(align_len),
        .rate_len(rate_len), .pen_max(pen_max), .vote_ok(vote_ok),
        .degraded(degraded), .cfg_bad(cfg_bad), .rail_penalty(penalty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        valid = '0;
        glitch = '0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        weight = 8'b01_01_01_01; thresh = 2; align_len = 4; rate_len = 1000; pen_max = 2;
        rst_n = 1'b0;
        step(2);
        chk("R10 vote in reset", int'(vote_ok), 0);
        chk("R10 degraded in reset", int'(degraded), 0);
        do_reset();
        chk("R10 vote after reset", int'(vote_ok), 0);
        chk("R10 penalties after reset", int'(penalty), 0);
        chk("R10 cfg ok", int'(cfg_bad), 0);
    endtask

    task automatic t_window();
        weight = 8'b00_01_01_01; thresh = 2; align_len = 8;
        do_reset();
        valid = 4'b0011;
        step(8);
        chk("R4 vote held in window", int'(vote_ok), 0);
        step(1);
        chk("R4 vote at window close", int'(vote_ok), 1);
    endtask

    task automatic t_weights();
        weight = {2'd0, 2'd1, 2'd2, 2'd3}; thresh = 5; align_len = 4;
        do_reset();
        valid = 4'b0110;
        step(10);
        chk("R2 total 3 below 5", int'(vote_ok), 0);
        valid = 4'b1110;
        step(3);
        chk("R1 zero weight ignored", int'(vote_ok), 0);
        valid = 4'b1111;
        step(1);
        chk("R2 total 6 meets", int'(vote_ok), 1);
        valid = 4'b1101;
        step(1);
        chk("R2 total 4 drops", int'(vote_ok), 0);
        valid = 4'b1111;
        step(4);
        chk("R5 new window after drop", int'(vote_ok), 0);
        step(1);
        chk("R5 vote after fresh window", int'(vote_ok), 1);
    endtask

    task automatic t_cfg();
        weight = 8'b00_00_01_01; thresh = 3; align_len = 2;
        do_reset();
        chk("R3 cfg_bad on high threshold", int'(cfg_bad), 1);
        valid = 4'b1111;
        step(10);
        chk("R3 vote blocked", int'(vote_ok), 0);
        thresh = 2;
        #1;
        chk("R3 cfg_bad clears", int'(cfg_bad), 0);
        step(1);
        chk("R3 vote after fix", int'(vote_ok), 1);
        thresh = 3;
        step(1);
        chk("R3 vote dropped again", int'(vote_ok), 0);
    endtask

    task automatic t_two_of_three();
        weight = 8'b00_01_01_01; thresh = 2; align_len = 3; pen_max = 1; rate_len = 1000;
        do_reset();
        valid = 4'b0111;
        step(4);
        chk("R9 vote up", int'(vote_ok), 1);
        for (int k = 0; k < 6; k++) begin
            valid = (k % 2 == 0) ? 4'b0011 : 4'b0111;
            glitch = (k < 3) ? 4'b0100 : 4'b0000;
            step(1);
            chk("R9 vote holds under flutter", int'(vote_ok), 1);
        end
        chk("R6 flutter rail penalty", int'(penalty[8 +: 4]), 3);
        chk("R6 quiet rail penalty", int'(penalty[0 +: 4]), 0);
        chk("R8 degraded set", int'(degraded), 1);
        chk("R8 vote kept while degraded", int'(vote_ok), 1);
    endtask

    task automatic t_penalty();
        weight = 8'b01_01_01_01; thresh = 1; align_len = 4; rate_len = 20; pen_max = 2;
        do_reset();
        glitch = 4'b0001;
        step(2);
        chk("R6 two glitches", int'(penalty[0 +: 4]), 2);
        chk("R8 at limit not degraded", int'(degraded), 0);
        step(1);
        glitch = '0;
        chk("R6 three glitches", int'(penalty[0 +: 4]), 3);
        chk("R8 over limit degraded", int'(degraded), 1);
        step(16);
        chk("R7 before decay", int'(penalty[0 +: 4]), 3);
        step(1);
        chk("R7 first decay", int'(penalty[0 +: 4]), 2);
        chk("R8 degraded clears", int'(degraded), 0);
        step(19);
        glitch = 4'b0001;
        step(1);
        glitch = '0;
        chk("R7 glitch and decay cancel", int'(penalty[0 +: 4]), 2);
        step(20);
        chk("R7 second decay", int'(penalty[0 +: 4]), 1);
        rate_len = 60000;
        do_reset();
        glitch = 4'b0010;
        step(20);
        glitch = '0;
        chk("R6 saturates at 15", int'(penalty[4 +: 4]), 15);
    endtask

    initial begin
        t_reset();
        t_window();
        t_weights();
        t_cfg();
        t_two_of_three();
        t_penalty();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule